// File: doc/BRIEF.md
# Programmable Oversampling Bit Timer

This block sits behind the baud-rate generator of a UART channel. It counts incoming baud ticks and tells the channel where each serial bit begins and where its middle is. It raises a bit-boundary strobe on the tick that closes a bit period. It raises a mid-bit sample strobe on the tick at the centre of the period. The number of ticks per bit comes from a 4-bit times-clock setting, and software can read and write that setting through a byte-wide port.

A setting of 4 to 15 gives that many ticks per bit. A setting of 0 to 3 falls back to the classic 16 ticks per bit, which is also the state after reset. When the receiver detects a start edge, it pulses an input that resets the phase count, so sampling lines up with the incoming character.

A new setting does not cut short the bit in progress. It is loaded at the next bit boundary, or at a start edge, whichever comes first.

Top module: `osbt_bit_timer`

## Requirements
- R1: After synchronous reset the setting reads back as 0x00, the phase count is zero, and the first bit period is 16 ticks long.
- R2: Setting codes 0, 1, 2 and 3 give a bit period of 16 ticks. Only bits [3:0] of a written byte are decoded, so writing 0x01, 0x10 or 0x11 also gives 16 ticks.
- R3: Setting codes 4 through 15 give a bit period of exactly that many ticks.
- R4: A read always returns the low nibble of the last byte written in bits [3:0], and zero in bits [7:4]. Bits [7:4] of a write have no effect on timing.
- R5: `bit_strobe` is high for one cycle, in the cycle that carries the tick on which the phase count equals the period minus one. The phase count then returns to zero.
- R6: `mid_strobe` is high in the cycle that carries the tick on which the phase count equals the period divided by two, rounded down. It is never high in the same cycle as `bit_strobe`.
- R7: A cycle with `start_edge` high sets the phase count to zero and adopts the current setting. It takes priority over a tick in the same cycle, and neither strobe fires in that cycle.
- R8: A write to the setting changes the active period only at the next bit boundary or start edge. A write in the same cycle as the boundary tick first applies to the bit after the one that follows.
- R9: In a cycle without a tick and without a start edge, the phase count holds and neither strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the times-clock setting |
| cfg_wr_data | input | 8 | Write data; only bits [3:0] are stored |
| cfg_rd_data | output | 8 | Read data: zero-extended stored nibble |
| baud_tick | input | 1 | One-cycle baud-rate tick |
| start_edge | input | 1 | Receiver start-edge pulse; restarts the phase |
| bit_strobe | output | 1 | Bit-boundary strobe |
| mid_strobe | output | 1 | Mid-bit sample strobe |

## Verification
The hardest situations to reach from the ports are the coincidences at a bit boundary. One is a setting write landing on the very tick that closes a bit. The other is a start edge arriving together with a tick. Both depend on the hidden phase count. The bench keeps its own model of that count and waits until the model says the next tick closes a bit, then places the write or the start edge there. Random stimulus with sparse ticks, occasional start edges and random setting bytes covers the remaining interleavings.

// File: rtl/osbt_pkg.sv
package osbt_pkg;
    localparam int CODE_W  = 4;
    localparam int DATA_W  = 8;
    localparam int CPB_MAX = 16;
    localparam int CPB_MIN = 4;
    localparam int CNT_W   = $clog2(CPB_MAX);
    localparam int CPB_W   = CNT_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CPB_W-1:0]  cpb_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_WRAP,
        ACT_RESTART
    } step_e;

    typedef struct packed {
        logic bit_end;
        logic mid;
    } strobe_t;

    // Map a setting code to ticks per bit; low codes fall back to the maximum.
    function automatic cpb_t cpb_of(code_t c);
        if (c < code_t'(CPB_MIN))
            return cpb_t'(CPB_MAX);
        else
            return cpb_t'(c);
    endfunction
endpackage

// File: rtl/osbt_cfg_reg.sv
module osbt_cfg_reg
    import osbt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_code,
    output logic [CW-1:0] code_q,
    output logic [DW-1:0] rd_data
);
    localparam int PAD_W = DW - CW;

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (wr_en)
            code_q <= wr_code;
    end

    assign rd_data = {{PAD_W{1'b0}}, code_q};
endmodule

// File: rtl/osbt_strobe_dec.sv
module osbt_strobe_dec
    import osbt_pkg::*;
(
    input  logic    tick,
    input  logic    restart,
    input  cnt_t    cnt,
    input  cpb_t    cpb,
    output step_e   action,
    output strobe_t strobes
);
    cpb_t cnt_ext;
    logic at_end;
    logic at_mid;

    assign cnt_ext = {1'b0, cnt};
    assign at_end  = (cnt_ext == cpb - cpb_t'(1));
    assign at_mid  = (cnt_ext == (cpb >> 1));

    always_comb begin
        strobes = '0;
        action  = ACT_HOLD;
        if (restart) begin
            action = ACT_RESTART;
        end else if (tick) begin
            strobes.bit_end = at_end;
            strobes.mid     = at_mid;
            action          = at_end ? ACT_WRAP : ACT_STEP;
        end
    end
endmodule

// File: rtl/osbt_phase_ctr.sv
module osbt_phase_ctr
    import osbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e action,
    input  code_t code,
    output cnt_t  cnt_q,
    output cpb_t  act_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= cpb_t'(CPB_MAX);
        end else begin
            unique case (action)
                ACT_STEP: cnt_q <= cnt_q + cnt_t'(1);
                ACT_WRAP, ACT_RESTART: begin
                    cnt_q <= '0;
                    act_q <= cpb_of(code);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/osbt_bit_timer.sv
module osbt_bit_timer
    import osbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic [DATA_W-1:0] cfg_rd_data,
    input  logic              baud_tick,
    input  logic              start_edge,
    output logic              bit_strobe,
    output logic              mid_strobe
);
    code_t   code_q;
    cnt_t    cnt_q;
    cpb_t    act_q;
    step_e   action;
    strobe_t strobes;
    logic    unused_hi;

    assign unused_hi = ^cfg_wr_data[DATA_W-1:CODE_W];

    osbt_cfg_reg #(.DW(DATA_W), .CW(CODE_W)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_code (cfg_wr_data[CODE_W-1:0]),
        .code_q  (code_q),
        .rd_data (cfg_rd_data)
    );

    osbt_strobe_dec dec_i (
        .tick    (baud_tick),
        .restart (start_edge),
        .cnt     (cnt_q),
        .cpb     (act_q),
        .action  (action),
        .strobes (strobes)
    );

    osbt_phase_ctr ctr_i (
        .clk    (clk),
        .rst    (rst),
        .action (action),
        .code   (code_q),
        .cnt_q  (cnt_q),
        .act_q  (act_q)
    );

    assign bit_strobe = strobes.bit_end;
    assign mid_strobe = strobes.mid;
endmodule

// File: rtl/osbt_bit_timer_chk.sv
module osbt_bit_timer_chk
    import osbt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [DATA_W-1:0] cfg_wr_data,
    input logic [DATA_W-1:0] cfg_rd_data,
    input logic              baud_tick,
    input logic              start_edge,
    input logic              bit_strobe,
    input logic              mid_strobe,
    input cnt_t              cnt,
    input cpb_t              act_cpb
);
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[DATA_W-1:CODE_W] == '0);

    a_r4_readback: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_rd_data[CODE_W-1:0] == $past(cfg_wr_data[CODE_W-1:0]));

    a_r9_quiet_no_tick: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |-> !bit_strobe && !mid_strobe);

    a_r9_hold_count: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !start_edge) |=> $stable(cnt));

    a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
        start_edge |=> cnt == '0);

    a_r7_restart_silent: assert property (@(posedge clk) disable iff (rst)
        start_edge |-> !bit_strobe && !mid_strobe);

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> cnt == '0);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bit_strobe && mid_strobe));

    a_r8_period_stable: assert property (@(posedge clk) disable iff (rst)
        !(bit_strobe || start_edge) |=> $stable(act_cpb));

    a_r3_period_range: assert property (@(posedge clk) disable iff (rst)
        act_cpb >= cpb_t'(CPB_MIN) && act_cpb <= cpb_t'(CPB_MAX));
endmodule

bind osbt_bit_timer osbt_bit_timer_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .baud_tick   (baud_tick),
    .start_edge  (start_edge),
    .bit_strobe  (bit_strobe),
    .mid_strobe  (mid_strobe),
    .cnt         (cnt_q),
    .act_cpb     (act_q)
);

// File: tb/osbt_bit_timer_tb_top.sv
`timescale 1ns/1ps
module osbt_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       baud_tick = 1'b0;
    logic       start_edge = 1'b0;
    logic       bit_strobe;
    logic       mid_strobe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // independent reference model
    int m_reg = 0;
    int m_cnt = 0;
    int m_cpb = 16;

    always #2 clk = ~clk;

    osbt_bit_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .baud_tick   (baud_tick),
        .start_edge  (start_edge),
        .bit_strobe  (bit_strobe),
        .mid_strobe  (mid_strobe)
    );

    function automatic int ticks_for(int code);
        return (code < 4) ? 16 : code;
    endfunction

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit tk, bit ed, bit wr, logic [7:0] wd);
        int e_bit;
        int e_mid;
        int nxt;
        @(negedge clk);
        baud_tick   = tk;
        start_edge  = ed;
        cfg_wr_en   = wr;
        cfg_wr_data = wd;
        #1;
        e_bit = (tk && !ed && m_cnt == m_cpb - 1) ? 1 : 0;
        e_mid = (tk && !ed && m_cnt == m_cpb / 2) ? 1 : 0;
        check("bit_strobe", int'(bit_strobe), e_bit);
        check("mid_strobe", int'(mid_strobe), e_mid);
        check("cfg_rd_data", int'(cfg_rd_data), m_reg);
        @(posedge clk);
        nxt = ticks_for(m_reg);
        if (ed) begin
            m_cnt = 0;
            m_cpb = nxt;
        end else if (tk) begin
            if (m_cnt == m_cpb - 1) begin
                m_cnt = 0;
                m_cpb = nxt;
            end else begin
                m_cnt++;
            end
        end
        if (wr) m_reg = int'(wd[3:0]);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic write_cfg(logic [7:0] v);
        step(1'b0, 1'b0, 1'b1, v);
    endtask

    // run ticks until the model says the next tick closes a bit
    task automatic to_last_tick();
        for (int i = 0; i < 40 && m_cnt != m_cpb - 1; i++) ticks(1);
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, 16-tick first period
        tag = "R1";
        #1 check("rd after reset", int'(cfg_rd_data), 0);
        ticks(34);

        // R2: low codes and aliases give 16 ticks
        tag = "R2";
        write_cfg(8'h02); ticks(40);
        write_cfg(8'h11); ticks(40);
        write_cfg(8'h10); ticks(34);
        write_cfg(8'h01); ticks(34);

        // R3: codes 4..15
        tag = "R3";
        for (int c = 4; c < 16; c++) begin
            write_cfg(8'(c));
            ticks(16 + 2 * c);
        end

        // R4: upper nibble ignored, read back low nibble
        tag = "R4";
        write_cfg(8'hA7); ticks(30);
        write_cfg(8'hF0); ticks(36);

        // R5, R6: odd and even periods with sparse ticks
        tag = "R5";
        write_cfg(8'h05); ticks(25);
        tag = "R6";
        write_cfg(8'h09);
        for (int i = 0; i < 60; i++) step(1'(i % 3 != 0), 1'b0, 1'b0, 8'h00);

        // R7: start edge mid-bit, and together with the closing tick
        tag = "R7";
        write_cfg(8'h06); ticks(9);
        step(1'b1, 1'b1, 1'b0, 8'h00);
        ticks(14);
        to_last_tick();
        write_cfg(8'h0C);
        step(1'b1, 1'b1, 1'b0, 8'h00);
        ticks(26);

        // R8: write mid-bit and on the closing tick
        tag = "R8";
        write_cfg(8'h08); ticks(20);
        ticks(3);
        write_cfg(8'h0D); ticks(30);
        to_last_tick();
        step(1'b1, 1'b0, 1'b1, 8'h04);
        ticks(30);

        // R9: idle gaps hold the phase
        tag = "R9";
        write_cfg(8'h07); ticks(10);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
        ticks(12);

        // random mix
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            bit tk = ($urandom % 10) < 7;
            bit ed = ($urandom % 64) == 0;
            bit wr = ($urandom % 50) == 0;
            step(tk, ed, wr, 8'($urandom));
        end

        @(negedge clk);
        baud_tick = 1'b0; start_edge = 1'b0; cfg_wr_en = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s: actual hung expected done", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule